// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a host-side configuration port and the configuration registers of the devices behind a primary bus and a tree of bridged secondary buses. Each request carries a 24-bit configuration address made of a bus number, an eight-bit slot number (a device number and a function number) and a register offset. The router resolves the bus number to one of its internal bus indexes. It checks that the addressed slot on that bus holds a device, then drives a single target port with a read or write strobe, the bus index, the slot fields, the offset, the access length and the write data.

Reads always complete one cycle after the request. On a hit the response carries the data the target returned in the request cycle. On a miss (an unknown bus number or an empty slot) the response is all ones over the width of the access. Writes that miss are dropped. Each bridge keeps its own secondary bus number. Software programs that number by writing to the bridge's own configuration bytes, and the same write still goes to the bridge's target port as a normal register write. Which slots hold devices, and where each bridge sits, are fixed by parameters.

Top module: `cfg_router`

## Requirements
- R1: On a routed request, `tgt_off` equals address bits 7:0, `tgt_dev` equals address bits 15:11 and `tgt_fn` equals bits 10:8. `tgt_len` and `tgt_wdata` carry the request's length and data in the same cycle.
- R2: Address bits 23:16 are first compared with the primary bus number, which is 0 and maps to bus index 0. They are then compared with each bridge's secondary number in order, bridge k mapping to bus index k+1. The first match is used, so a number shared by two bridges selects the lower-indexed one.
- R3: `tgt_rd` or `tgt_wr` is raised, never both, only in the cycle of a request whose bus matched and whose slot is marked present for that bus index. It is raised for every such request.
- R4: A read that misses returns `rsp_rdata` of 0x000000FF for length 1 and 0x0000FFFF for length 2. Length 4, and any length code other than 1 or 2, returns 0xFFFFFFFF.
- R5: Every read raises `rsp_valid` for one cycle, one cycle after the request. On a hit, the response data equals the `tgt_rdata` present in the request cycle.
- R6: A write that misses raises no target strobe and leaves every bridge's secondary number unchanged.
- R7: A write hitting a bridge's slot on its parent bus at offset 0x19, of any length, loads data bits 7:0 into that bridge's secondary number.
- R8: A write hitting a bridge's slot at offset 0x18 with a length code other than 1 loads data bits 15:8. A length-1 write at offset 0x18 leaves the number unchanged.
- R9: A write that updates a bridge number is itself routed with the numbers in force before it and still raises `tgt_wr`. The new number applies from the next request.
- R10: After reset every secondary number is 0, so bus number 0 reaches only the primary bus and no other bus number matches until a bridge is programmed.
- R11: A write, or a cycle with no request, gives no `rsp_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus number [23:16], slot [15:8], offset [7:0] |
| req_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| tgt_rd | output | 1 | Read strobe to the selected target |
| tgt_wr | output | 1 | Write strobe to the selected target |
| tgt_bus | output | BIDX_W | Selected bus index (0 = primary, k+1 = bridge k) |
| tgt_dev | output | 5 | Device number |
| tgt_fn | output | 3 | Function number |
| tgt_off | output | 8 | Register offset |
| tgt_len | output | 3 | Access length |
| tgt_wdata | output | 32 | Write data to the target |
| tgt_rdata | input | 32 | Read data from the target, same cycle |

## Verification
The two functions that share a cycle are a bridge reprogramming its own secondary number and the routing of that very write. The bench provokes this by writing to a bridge's number bytes and checking the strobe and bus index in that cycle against the old numbers. It then checks that the very next request resolves through the new number and that the old number no longer matches. A second overlap comes from two bridges programmed with the same number. Priority is judged by sweeping every slot under that number and comparing each hit against an independent model of the present masks.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

   localparam int unsigned ADDR_W = 24;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned SLOTS  = 256;
   localparam int unsigned LEN_W  = 3;

   localparam logic [7:0] OFF_SEC_LO = 8'h18;
   localparam logic [7:0] OFF_SEC_HI = 8'h19;

   typedef struct packed {
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [7:0] off;
   } cfg_addr_t;

   function automatic logic [DATA_W-1:0] miss_fill(input logic [LEN_W-1:0] len);
      logic [DATA_W-1:0] v;
      case (len)
         3'd1:    v = 32'h0000_00FF;
         3'd2:    v = 32'h0000_FFFF;
         default: v = 32'hFFFF_FFFF;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/cfgr_bus_match.sv
module cfgr_bus_match #(
   parameter int unsigned NBR         = 2,
   parameter logic [7:0]  PRIMARY_NUM = 8'h00,
   localparam int unsigned BIDX_W     = $clog2(NBR + 1)
) (
   input  logic [7:0]        req_bus,
   input  logic [NBR*8-1:0]  sec_nums,
   output logic              match,
   output logic [BIDX_W-1:0] idx
);

   logic [NBR-1:0] hit_vec;

   genvar k;
   generate
      for (k = 0; k < NBR; k++) begin : g_cmp
         assign hit_vec[k] = (sec_nums[k*8 +: 8] == req_bus);
      end
   endgenerate

   always_comb begin
      match = 1'b0;
      idx   = '0;
      for (int j = NBR - 1; j >= 0; j--) begin
         if (hit_vec[j]) begin
            match = 1'b1;
            idx   = BIDX_W'(j + 1);
         end
      end
      if (req_bus == PRIMARY_NUM) begin
         match = 1'b1;
         idx   = '0;
      end
   end

endmodule

// File: rtl/cfgr_bridge_reg.sv
module cfgr_bridge_reg
   import cfgr_pkg::*;
#(
   parameter int unsigned NBR    = 2,
   parameter int unsigned PARENT = 0,
   parameter logic [7:0]  SLOT   = 8'h08,
   localparam int unsigned BIDX_W = $clog2(NBR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [BIDX_W-1:0] hit_bus,
   input  logic [7:0]        hit_slot,
   input  logic [7:0]        off,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] wdata,
   output logic [7:0]        sec_num
);

   logic sel;
   assign sel = wr_hit && (hit_bus == BIDX_W'(PARENT)) && (hit_slot == SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_num <= 8'h00;
      end else if (sel) begin
         if (off == OFF_SEC_HI)
            sec_num <= wdata[7:0];
         else if (off == OFF_SEC_LO && len != 3'd1)
            sec_num <= wdata[15:8];
      end
   end

endmodule

// File: rtl/cfgr_rsp.sv
module cfgr_rsp
   import cfgr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              hit,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] tgt_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_req;
         if (rd_req)
            rsp_rdata <= hit ? tgt_rdata : miss_fill(len);
      end
   end

endmodule

// File: rtl/cfg_router.sv
module cfg_router
   import cfgr_pkg::*;
#(
   parameter int unsigned NBR         = 2,
   parameter logic [7:0]  PRIMARY_NUM = 8'h00,
   parameter int unsigned BR_PARENT [NBR] = '{0, 1},
   parameter logic [7:0]  BR_SLOT   [NBR] = '{8'h08, 8'h10},
   parameter logic [SLOTS-1:0] PRESENT [NBR+1] = '{
      256'h1_0000_0301,
      256'h0101_0000,
      {1'b1, 254'b0, 1'b1}
   },
   localparam int unsigned BIDX_W = $clog2(NBR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [23:0]       req_addr,
   input  logic [2:0]        req_len,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              tgt_rd,
   output logic              tgt_wr,
   output logic [BIDX_W-1:0] tgt_bus,
   output logic [4:0]        tgt_dev,
   output logic [2:0]        tgt_fn,
   output logic [7:0]        tgt_off,
   output logic [2:0]        tgt_len,
   output logic [31:0]       tgt_wdata,
   input  logic [31:0]       tgt_rdata
);

   genvar k;
   generate
      if (NBR < 1) begin : g_bad_nbr
         $error("cfg_router: NBR must be at least 1");
      end
      for (k = 0; k < NBR; k++) begin : g_chk_cfg
         if (BR_PARENT[k] > k) begin : g_bad_parent
            $error("cfg_router: bridge parent must be primary or an earlier bridge");
         end else if (!PRESENT[BR_PARENT[k]][BR_SLOT[k]]) begin : g_bad_slot
            $error("cfg_router: bridge slot not marked present");
         end
      end
   endgenerate

   cfg_addr_t        a;
   logic [NBR*8-1:0] sec_flat;
   logic             bus_match;
   logic [BIDX_W-1:0] bus_idx;
   logic             slot_present;
   logic             hit;
   logic             wr_hit;

   assign a = cfg_addr_t'(req_addr);

   cfgr_bus_match #(
      .NBR         (NBR),
      .PRIMARY_NUM (PRIMARY_NUM)
   ) u_match (
      .req_bus  (a.bus),
      .sec_nums (sec_flat),
      .match    (bus_match),
      .idx      (bus_idx)
   );

   always_comb begin
      slot_present = 1'b0;
      for (int b = 0; b <= NBR; b++) begin
         if (bus_idx == BIDX_W'(b))
            slot_present = PRESENT[b][{a.dev, a.fn}];
      end
   end

   assign hit    = bus_match && slot_present;
   assign wr_hit = req_valid && req_write && hit;

   generate
      for (k = 0; k < NBR; k++) begin : g_bridge
         cfgr_bridge_reg #(
            .NBR    (NBR),
            .PARENT (BR_PARENT[k]),
            .SLOT   (BR_SLOT[k])
         ) u_br (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit),
            .hit_bus  (bus_idx),
            .hit_slot ({a.dev, a.fn}),
            .off      (a.off),
            .len      (req_len),
            .wdata    (req_wdata),
            .sec_num  (sec_flat[k*8 +: 8])
         );
      end
   endgenerate

   assign tgt_rd    = req_valid && !req_write && hit;
   assign tgt_wr    = wr_hit;
   assign tgt_bus   = bus_idx;
   assign tgt_dev   = a.dev;
   assign tgt_fn    = a.fn;
   assign tgt_off   = a.off;
   assign tgt_len   = req_len;
   assign tgt_wdata = req_wdata;

   cfgr_rsp u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (req_valid && !req_write),
      .hit       (hit),
      .len       (req_len),
      .tgt_rdata (tgt_rdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
   parameter int unsigned NBR = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [23:0]      req_addr,
   input logic [2:0]       req_len,
   input logic             tgt_rd,
   input logic             tgt_wr,
   input logic [4:0]       tgt_dev,
   input logic [2:0]       tgt_fn,
   input logic [7:0]       tgt_off,
   input logic             rsp_valid,
   input logic [31:0]      rsp_rdata,
   input logic [NBR*8-1:0] sec_flat
);

   a_r1_fields_follow_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rd || tgt_wr) |-> (tgt_off == req_addr[7:0] && {tgt_dev, tgt_fn} == req_addr[15:8]));

   a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(tgt_rd && tgt_wr));

   a_r3_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rd || tgt_wr) |-> req_valid);

   a_r4_byte_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !tgt_rd && req_len == 3'd1) |=> (rsp_rdata == 32'h0000_00FF));

   a_r5_read_responds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   a_r11_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);

   a_r6_numbers_need_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_wr |=> $stable(sec_flat));

endmodule

bind cfg_router cfgr_checker #(.NBR(NBR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_len   (req_len),
   .tgt_rd    (tgt_rd),
   .tgt_wr    (tgt_wr),
   .tgt_dev   (tgt_dev),
   .tgt_fn    (tgt_fn),
   .tgt_off   (tgt_off),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .sec_flat  (sec_flat)
);

// File: tb/sim_cfg_router.sv
module sim_cfg_router;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [2:0]  req_len = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        tgt_rd, tgt_wr;
   logic [1:0]  tgt_bus;
   logic [4:0]  tgt_dev;
   logic [2:0]  tgt_fn;
   logic [7:0]  tgt_off;
   logic [2:0]  tgt_len;
   logic [31:0] tgt_wdata;
   logic [31:0] tgt_rdata;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_sec [2];

   always #(CLK_PERIOD / 2) clk = ~clk;

   // device model: data identifies where the access landed
   assign tgt_rdata = {6'b0, tgt_bus, tgt_dev, tgt_fn, tgt_off, 8'h5A};

   cfg_router u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr),
      .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn), .tgt_off(tgt_off),
      .tgt_len(tgt_len), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit present(input int idx, input int slot);
      case (idx)
         0: return slot == 8'h00 || slot == 8'h08 || slot == 8'h09 || slot == 8'h20;
         1: return slot == 8'h10 || slot == 8'h18;
         2: return slot == 8'h00 || slot == 8'hFF;
         default: return 1'b0;
      endcase
   endfunction

   task automatic route(input logic [23:0] a, output bit hit, output int idx);
      idx = -1;
      if (a[23:16] == 8'h00) idx = 0;
      else begin
         for (int k = 0; k < 2; k++)
            if (idx < 0 && m_sec[k] == a[23:16]) idx = k + 1;
      end
      hit = (idx >= 0) && present(idx, int'(a[15:8]));
   endtask

   // one request; starts and ends just after a falling edge
   task automatic do_req(input bit w, input logic [23:0] a, input logic [2:0] len,
                         input logic [31:0] d, output bit got_hit, output int got_idx);
      bit hit; int idx; logic [31:0] exp;
      route(a, hit, idx);
      req_valid = 1'b1; req_write = w; req_addr = a; req_len = len; req_wdata = d;
      #1;
      got_hit = w ? tgt_wr : tgt_rd;
      got_idx = int'(tgt_bus);
      chk(got_hit == hit, "R3 strobe", longint'(got_hit), longint'(hit));
      chk(!(w ? tgt_rd : tgt_wr), "R3 wrong strobe", 1, 0);
      if (hit) begin
         chk(got_idx == idx, "R2 bus index", got_idx, idx);
         chk(tgt_off == a[7:0] && {tgt_dev, tgt_fn} == a[15:8] && tgt_len == len
             && (!w || tgt_wdata == d), "R1 fields",
             longint'({tgt_dev, tgt_fn, tgt_off}), longint'(a[15:0]));
      end
      @(posedge clk);
      if (w && hit) begin
         int k = -1;
         if (idx == 0 && a[15:8] == 8'h08) k = 0;
         if (idx == 1 && a[15:8] == 8'h10) k = 1;
         if (k >= 0) begin
            if (a[7:0] == 8'h19) m_sec[k] = d[7:0];
            else if (a[7:0] == 8'h18 && len != 3'd1) m_sec[k] = d[15:8];
         end
      end
      @(negedge clk);
      if (w) chk(rsp_valid == 1'b0, "R11 write rsp", longint'(rsp_valid), 0);
      else begin
         chk(rsp_valid == 1'b1, "R5 rsp_valid", longint'(rsp_valid), 1);
         if (hit) exp = {8'(idx), a[15:8], a[7:0], 8'h5A};
         else exp = (len == 3'd1) ? 32'hFF : (len == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
         chk(rsp_rdata == exp, hit ? "R5 hit data" : "R4 miss fill",
             longint'(rsp_rdata), longint'(exp));
      end
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic expect_route(input bit w, input logic [23:0] a, input logic [2:0] len,
                               input logic [31:0] d, input bit e_hit, input int e_idx,
                               input string tag);
      bit h; int i;
      do_req(w, a, len, d, h, i);
      chk(h == e_hit, tag, longint'(h), longint'(e_hit));
      if (e_hit) chk(i == e_idx, tag, i, e_idx);
   endtask

   task automatic sweep(input logic [7:0] num);
      bit h; int i;
      for (int s = 0; s < 256; s++)
         do_req(1'b0, {num, 8'(s), 8'(s) ^ 8'h3C}, 3'd4, 32'h0, h, i);
   endtask

   initial begin
      m_sec[0] = 8'h00; m_sec[1] = 8'h00;
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R5 reset rsp_valid", longint'(rsp_valid), 0);
      chk(!tgt_rd && !tgt_wr, "R3 reset strobes", longint'({tgt_rd, tgt_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 idle", longint'(rsp_valid), 0);

      // R10: unprogrammed bridges, number 0 is the primary only
      expect_route(1'b0, 24'h00_2004, 3'd4, 0, 1'b1, 0, "R10 primary");
      expect_route(1'b0, 24'h00_1000, 3'd4, 0, 1'b0, 0, "R10 bus1 slot via 0");
      expect_route(1'b0, 24'h01_1000, 3'd4, 0, 1'b0, 0, "R10 bus 1 unknown");
      sweep(8'h00); sweep(8'h01); sweep(8'hFF);

      // R7: program bridge 0 through offset 0x19; R9 same-cycle routing
      expect_route(1'b1, 24'h00_0819, 3'd1, 32'h0000_AB05, 1'b1, 0, "R9 bridge write forwarded");
      expect_route(1'b0, 24'h05_1000, 3'd4, 0, 1'b1, 1, "R7 new number routes");
      // R8: length 1 at 0x18 ignored, length 2 loads bits 15:8
      expect_route(1'b1, 24'h05_1018, 3'd1, 32'h0000_0700, 1'b1, 1, "R8 len1 forwarded");
      expect_route(1'b0, 24'h07_FF00, 3'd4, 0, 1'b0, 0, "R8 len1 no change");
      expect_route(1'b1, 24'h05_1018, 3'd2, 32'h0000_0733, 1'b1, 1, "R8 len2 write");
      expect_route(1'b0, 24'h07_FF00, 3'd4, 0, 1'b1, 2, "R8 len2 loads");
      sweep(8'h05); sweep(8'h07);

      // R9: renumber bridge 0 from 5 to 3; next request sees 3, not 5
      expect_route(1'b1, 24'h00_0819, 3'd4, 32'h0000_0003, 1'b1, 0, "R9 renumber write");
      expect_route(1'b0, 24'h03_1000, 3'd4, 0, 1'b1, 1, "R9 new number next");
      expect_route(1'b0, 24'h05_1000, 3'd4, 0, 1'b0, 0, "R9 old number gone");

      // R2: both bridges on number 3, lower index wins
      expect_route(1'b1, 24'h03_1019, 3'd1, 32'h0000_0003, 1'b1, 1, "R2 dup write");
      expect_route(1'b0, 24'h03_FF00, 3'd4, 0, 1'b0, 0, "R2 dup shadowed");
      sweep(8'h03);
      expect_route(1'b1, 24'h03_1018, 3'd4, 32'h0000_0700, 1'b1, 1, "R8 len4 write");
      expect_route(1'b0, 24'h07_FF00, 3'd4, 0, 1'b1, 2, "R8 len4 loads");

      // R6: write misses change nothing
      expect_route(1'b1, 24'h09_0819, 3'd1, 32'h0000_0009, 1'b0, 0, "R6 unknown bus write");
      expect_route(1'b0, 24'h09_0800, 3'd4, 0, 1'b0, 0, "R6 no renumber");
      expect_route(1'b1, 24'h00_3019, 3'd1, 32'h0000_0007, 1'b0, 0, "R6 empty slot write");
      expect_route(1'b0, 24'h03_1000, 3'd4, 0, 1'b1, 1, "R6 bridge 0 kept");
      expect_route(1'b0, 24'h07_0000, 3'd4, 0, 1'b1, 2, "R6 bridge 1 kept");

      // R4: miss fill per length code
      expect_route(1'b0, 24'h42_0000, 3'd1, 0, 1'b0, 0, "R4 len1 miss");
      expect_route(1'b0, 24'h42_0000, 3'd2, 0, 1'b0, 0, "R4 len2 miss");
      expect_route(1'b0, 24'h42_0000, 3'd3, 0, 1'b0, 0, "R4 len3 miss");
      expect_route(1'b0, 24'h00_0900, 3'd1, 0, 1'b1, 0, "R5 len1 hit");
      sweep(8'h07); sweep(8'h09);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule